// File: doc/BRIEF.md
# Precision Time Protocol Clock Counter

This block keeps a running time-of-day value for hardware timestamping under IEEE 1588. The time is held as a 32-bit whole-seconds count and a 30-bit nanoseconds count. On every clock cycle the nanoseconds count grows by a programmable step. When it reaches one billion it folds back to the remainder and the seconds count goes up. The live value is driven on two output buses so that capture logic elsewhere can take a timestamp on any cycle.

Software reaches the counter through a small register port with four word locations. It can load either half of the time directly and set the per-cycle step. It can also queue a one-shot signed correction of less than one second, which moves the time forward or back without a full reload. A coherent two-access read is supported: reading the nanoseconds location captures the seconds count into a holding register, and a later read of the seconds location returns that captured value.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset, seconds and nanoseconds are both zero, the step reads back as RESET_INC (default 5), no correction is pending, and the seconds location reads zero.
- R2: When no write or correction applies, each clock adds the step to the nanoseconds count. A result of 1,000,000,000 or more has 1,000,000,000 taken off and adds one to seconds.
- R3: Address 2 holds the step in bits 7:0. A write takes effect from the next cycle. A step of zero holds the time still.
- R4: A write to address 1 loads seconds and a write to address 0 loads nanoseconds from bits 29:0. In that cycle the time takes no step and the other half is unchanged. A nanoseconds write of 1,000,000,000 or more is ignored, and that cycle steps normally.
- R5: A write to address 3 with bit 31 clear queues a forward correction of bits 29:0 nanoseconds. The cycle of that write steps normally. The next cycle adds step plus correction, carrying one or two into seconds as needed.
- R6: With bit 31 set, the correction is subtracted. A result below zero borrows one second and leaves 1,000,000,000 minus the deficit.
- R7: A correction is applied exactly once and then clears itself.
- R8: A correction write whose magnitude in bits 29:0 is 1,000,000,000 or more is ignored.
- R9: A read of address 0 returns live nanoseconds and captures live seconds. A read of address 1 returns the captured value, which stays unchanged as the time advances.
- R10: A pending correction is held, not lost, through a cycle that carries a direct time write, and it is applied on the next cycle without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Word select: 0 nanoseconds, 1 seconds, 2 step, 3 correction |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word, valid in the strobe cycle |
| tod_sec | output | SEC_W | Live seconds count |
| tod_ns | output | 30 | Live nanoseconds count |

## Verification
The time is loaded just below the one-second boundary so that the step lands exactly on one billion. This separates a correct fold at equality from an off-by-one compare. A large step with a near-maximum forward correction forces a double carry into seconds. Two backward corrections are tried, one that crosses zero and one that does not, to tell a correct borrow from a wrapped subtract. A zero step, an out-of-range load, an out-of-range correction and a correction queued just before a direct load each show whether the write priority and the one-shot behaviour keep the right value. The capture register is read after the live seconds count has moved on, which tells a coherent read from a live read.

// File: rtl/ptp_tod_pkg.sv
package ptp_tod_pkg;
    localparam int DATA_W = 32;
    localparam int NS_W   = 30;
    localparam int ADJ_SIGN_BIT = 31;
    localparam logic [DATA_W-1:0] NS_PER_SEC     = 32'd1_000_000_000;
    localparam logic [DATA_W-1:0] TWO_NS_PER_SEC = 32'd2_000_000_000;

    typedef enum logic [1:0] {
        SEL_NS  = 2'd0,
        SEL_SEC = 2'd1,
        SEL_INC = 2'd2,
        SEL_ADJ = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/ptp_tod_step.sv
module ptp_tod_step
    import ptp_tod_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int INC_W = 8
) (
    input  logic [SEC_W-1:0] sec_i,
    input  logic [NS_W-1:0]  ns_i,
    input  logic [INC_W-1:0] incr_i,
    input  logic             adj_en_i,
    input  logic             adj_neg_i,
    input  logic [NS_W-1:0]  adj_mag_i,
    output logic [SEC_W-1:0] sec_nx_o,
    output logic [NS_W-1:0]  ns_nx_o
);
    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] mag;
    logic [DATA_W-1:0] sum;

    always_comb begin
        base     = DATA_W'(ns_i) + DATA_W'(incr_i);
        mag      = DATA_W'(adj_mag_i);
        sec_nx_o = sec_i;
        if (adj_en_i && adj_neg_i) begin
            if (base >= mag) begin
                sum = base - mag;
                if (sum >= NS_PER_SEC) begin
                    sum      = sum - NS_PER_SEC;
                    sec_nx_o = sec_i + SEC_W'(1);
                end
            end else begin
                // deficit: borrow a whole second
                sum      = base + NS_PER_SEC - mag;
                sec_nx_o = sec_i - SEC_W'(1);
            end
        end else begin
            sum = base + (adj_en_i ? mag : '0);
            if (sum >= TWO_NS_PER_SEC) begin
                sum      = sum - TWO_NS_PER_SEC;
                sec_nx_o = sec_i + SEC_W'(2);
            end else if (sum >= NS_PER_SEC) begin
                sum      = sum - NS_PER_SEC;
                sec_nx_o = sec_i + SEC_W'(1);
            end
        end
        ns_nx_o = NS_W'(sum);
    end
endmodule

// File: rtl/ptp_tod_regs.sv
module ptp_tod_regs
    import ptp_tod_pkg::*;
#(
    parameter int SEC_W     = 32,
    parameter int INC_W     = 8,
    parameter int RESET_INC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [SEC_W-1:0]  sec_live_i,
    input  logic [NS_W-1:0]   ns_live_i,
    input  logic              adj_take_i,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [INC_W-1:0]  incr_o,
    output logic              adj_pend_o,
    output logic              adj_neg_o,
    output logic [NS_W-1:0]   adj_mag_o,
    output logic              wr_sec_o,
    output logic              wr_ns_o
);
    typedef struct packed {
        logic [INC_W-1:0] incr;
        logic             pend;
        logic             neg;
        logic [NS_W-1:0]  mag;
        logic [SEC_W-1:0] shadow;
    } regs_t;

    regs_t    regs_d, regs_q;
    reg_sel_e sel;
    logic     wr_adj_ok;
    logic     in_range;

    always_comb begin
        sel       = reg_sel_e'(reg_addr);
        in_range  = DATA_W'(NS_W'(reg_wdata)) < NS_PER_SEC;
        wr_sec_o  = reg_wr && (sel == SEL_SEC);
        wr_ns_o   = reg_wr && (sel == SEL_NS) && in_range;
        wr_adj_ok = reg_wr && (sel == SEL_ADJ) && in_range;

        regs_d = regs_q;
        if (reg_wr && (sel == SEL_INC)) begin
            regs_d.incr = INC_W'(reg_wdata);
        end
        if (wr_adj_ok) begin
            regs_d.pend = 1'b1;
            regs_d.neg  = reg_wdata[ADJ_SIGN_BIT];
            regs_d.mag  = NS_W'(reg_wdata);
        end else if (adj_take_i) begin
            regs_d.pend = 1'b0;
        end
        if (reg_rd && (sel == SEL_NS)) begin
            regs_d.shadow = sec_live_i;
        end

        unique case (sel)
            SEL_NS:  reg_rdata = DATA_W'(ns_live_i);
            SEL_SEC: reg_rdata = DATA_W'(regs_q.shadow);
            SEL_INC: reg_rdata = DATA_W'(regs_q.incr);
            default: reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q      <= '0;
            regs_q.incr <= INC_W'(RESET_INC);
        end else begin
            regs_q <= regs_d;
        end
    end

    assign incr_o     = regs_q.incr;
    assign adj_pend_o = regs_q.pend;
    assign adj_neg_o  = regs_q.neg;
    assign adj_mag_o  = regs_q.mag;

    // R7: a taken correction does not stay pending
    a_r7_adj_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.pend && adj_take_i && !wr_adj_ok) |=> !regs_q.pend);

    // R8: an out-of-range correction queues nothing
    a_r8_big_adj_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd3 && !regs_q.pend
         && DATA_W'(reg_wdata[NS_W-1:0]) >= NS_PER_SEC) |=> !regs_q.pend);

    // R9: the nanoseconds read captures the seconds count
    a_r9_shadow_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd0) |=> regs_q.shadow == $past(sec_live_i));
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
    import ptp_tod_pkg::*;
#(
    parameter int SEC_W     = 32,
    parameter int INC_W     = 8,
    parameter int RESET_INC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [SEC_W-1:0]  tod_sec,
    output logic [NS_W-1:0]   tod_ns
);
    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } tod_t;

    tod_t             tod_d, tod_q;
    logic [INC_W-1:0] incr;
    logic             adj_pend, adj_neg, adj_take;
    logic [NS_W-1:0]  adj_mag;
    logic             wr_sec, wr_ns;
    logic [SEC_W-1:0] step_sec;
    logic [NS_W-1:0]  step_ns;

    ptp_tod_regs #(
        .SEC_W(SEC_W), .INC_W(INC_W), .RESET_INC(RESET_INC)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .sec_live_i (tod_q.sec),
        .ns_live_i  (tod_q.ns),
        .adj_take_i (adj_take),
        .reg_rdata  (reg_rdata),
        .incr_o     (incr),
        .adj_pend_o (adj_pend),
        .adj_neg_o  (adj_neg),
        .adj_mag_o  (adj_mag),
        .wr_sec_o   (wr_sec),
        .wr_ns_o    (wr_ns)
    );

    ptp_tod_step #(
        .SEC_W(SEC_W), .INC_W(INC_W)
    ) u_step (
        .sec_i     (tod_q.sec),
        .ns_i      (tod_q.ns),
        .incr_i    (incr),
        .adj_en_i  (adj_pend),
        .adj_neg_i (adj_neg),
        .adj_mag_i (adj_mag),
        .sec_nx_o  (step_sec),
        .ns_nx_o   (step_ns)
    );

    always_comb begin
        tod_d    = tod_q;
        adj_take = 1'b0;
        if (wr_sec) begin
            tod_d.sec = SEC_W'(reg_wdata);
        end else if (wr_ns) begin
            tod_d.ns = NS_W'(reg_wdata);
        end else begin
            tod_d.sec = step_sec;
            tod_d.ns  = step_ns;
            adj_take  = adj_pend;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tod_q <= '0;
        else        tod_q <= tod_d;
    end

    assign tod_sec = tod_q.sec;
    assign tod_ns  = tod_q.ns;

    // R2: nanoseconds always stay below one second
    a_r2_ns_below_second: assert property (@(posedge clk) disable iff (!rst_n)
        DATA_W'(tod_q.ns) < NS_PER_SEC);

    // R2: a plain step moves seconds by zero or one
    a_r2_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!adj_pend && !wr_sec && !wr_ns) |=>
        (tod_q.sec == $past(tod_q.sec) || tod_q.sec == $past(tod_q.sec) + SEC_W'(1)));

    // R3: a zero step freezes the time
    a_r3_zero_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (incr == '0 && !adj_pend && !wr_sec && !wr_ns) |=>
        ($stable(tod_q.sec) && $stable(tod_q.ns)));

    // R4: a seconds load replaces seconds and holds nanoseconds
    a_r4_sec_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sec |=> (tod_q.sec == $past(reg_wdata[SEC_W-1:0]) && $stable(tod_q.ns)));

    // R10: a direct load keeps a queued correction
    a_r10_adj_held: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_pend && (wr_sec || wr_ns)) |=> adj_pend);
endmodule

// File: tb/ptp_tod_counter_tb.sv
module ptp_tod_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [31:0] tod_sec;
    logic [29:0] tod_ns;

    typedef struct {
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t exp_q[$];
    int    n_cmp  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    localparam logic [1:0] A_NS = 2'd0, A_SEC = 2'd1, A_INC = 2'd2, A_ADJ = 2'd3;

    always #2.5 clk = ~clk;

    ptp_tod_counter u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tod_sec   (tod_sec),
        .tod_ns    (tod_ns)
    );

    // each task is entered at a falling edge and spans one rising edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string req);
        item_t it;
        it.exp = e;
        it.req = req;
        exp_q.push_back(it);
        reg_rd   = 1'b1;
        reg_addr = a;
        @(negedge clk);
        reg_rd   = 1'b0;
    endtask

    // monitor: compares read data after the inputs settle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (reg_rd) begin
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL monitor: read with no expected item, got %0d", reg_rdata);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    n_cmp++;
                    if (reg_rdata !== it.exp) begin
                        n_fail++;
                        $display("FAIL %s: got %0d expected %0d", it.req, reg_rdata, it.exp);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_NS,  32'd0, "R1");
        rd(A_SEC, 32'd0, "R1");
        rd(A_INC, 32'd5, "R1");

        // R2: exact fold at one billion
        wr(A_NS,  32'd999_999_990);
        wr(A_SEC, 32'd7);
        rd(A_NS,  32'd999_999_990, "R2");
        rd(A_SEC, 32'd7, "R2");
        rd(A_NS,  32'd0, "R2");
        rd(A_SEC, 32'd8, "R2");

        // R9: captured seconds ignore a later carry
        wr(A_NS,  32'd999_999_995);
        rd(A_NS,  32'd999_999_995, "R9");
        rd(A_SEC, 32'd8, "R9");
        rd(A_NS,  32'd5, "R9");
        rd(A_SEC, 32'd9, "R9");

        // R3: programmable step and freeze
        wr(A_INC, 32'd200);
        wr(A_NS,  32'd100);
        rd(A_NS,  32'd100, "R3");
        rd(A_NS,  32'd300, "R3");
        rd(A_INC, 32'd200, "R3");
        wr(A_INC, 32'd0);
        wr(A_NS,  32'd4242);
        rd(A_NS,  32'd4242, "R3");
        rd(A_NS,  32'd4242, "R3");
        wr(A_INC, 32'd5);

        // R4: direct loads and the out-of-range nanoseconds load
        wr(A_NS,  32'd1000);
        wr(A_SEC, 32'd50);
        rd(A_NS,  32'd1000, "R4");
        rd(A_SEC, 32'd50, "R4");
        wr(A_NS,  32'd1_000_000_000);
        rd(A_NS,  32'd1015, "R4");

        // R5 / R7: forward correction, applied once
        wr(A_NS,  32'd1000);
        wr(A_ADJ, 32'd500);
        rd(A_NS,  32'd1005, "R5");
        rd(A_NS,  32'd1510, "R5");
        rd(A_NS,  32'd1515, "R7");

        // R5: double carry with the widest step
        wr(A_INC, 32'd255);
        wr(A_NS,  32'd999_999_700);
        wr(A_SEC, 32'd3);
        wr(A_ADJ, 32'd999_999_999);
        rd(A_NS,  32'd999_999_955, "R5");
        rd(A_NS,  32'd209, "R5");
        rd(A_SEC, 32'd5, "R5");
        wr(A_INC, 32'd5);

        // R6: backward correction with and without borrow
        wr(A_NS,  32'd100);
        wr(A_SEC, 32'd20);
        wr(A_ADJ, 32'h8000_03E8);
        rd(A_NS,  32'd105, "R6");
        rd(A_NS,  32'd999_999_110, "R6");
        rd(A_SEC, 32'd19, "R6");
        wr(A_NS,  32'd5000);
        wr(A_ADJ, 32'h8000_03E8);
        rd(A_NS,  32'd5005, "R6");
        rd(A_NS,  32'd4010, "R6");

        // R8: out-of-range correction does nothing
        wr(A_NS,  32'd100);
        wr(A_ADJ, 32'd1_000_000_000);
        rd(A_NS,  32'd105, "R8");
        rd(A_NS,  32'd110, "R8");

        // R10: correction survives a direct load
        wr(A_NS,  32'd100);
        wr(A_ADJ, 32'd50);
        wr(A_NS,  32'd2000);
        rd(A_NS,  32'd2000, "R10");
        rd(A_NS,  32'd2055, "R10");
        rd(A_NS,  32'd2060, "R10");

        @(negedge clk);
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule